// File: doc/BRIEF.md
# Serial Character Frame Timer

This block measures the duration of one asynchronous or synchronous serial character, so that a serial controller knows when the character on the line is complete. For every channel it holds one transmit timer and one receive timer. Each timer builds the frame length from the current mode settings: data bits, an optional parity bit, the start and stop overhead, and a clock-rate multiplier. It then counts transitions of that direction's bit-clock input and emits a one-cycle completion pulse when the frame is finished.

Lengths are counted in half-bit units, so a one-and-a-half stop bit setting is exact. A start strobe arms an idle timer with the current length. A cancel strobe returns the timer to idle at once. The length is captured when the timer is armed, so software may reprogram the mode fields while a character is still in flight. The new values take effect on the next character.

The bit-clock inputs are expected to be synchronous to `clk`. A caller with a truly asynchronous line clock places a synchronizer ahead of this block. The reset input is asserted asynchronously and released through an internal two-stage synchronizer.

Top module: `char_frame_timer`

## Requirements
- R1: The frame length in half-bit units is 2 per data bit, plus 2 when the parity flag is 1, plus a stop overhead chosen by the 2-bit stop code: 00 adds 0 (sync mode), 01 adds 4, 10 adds 5 and 11 adds 6. This sum is then multiplied as in R4.
- R2: The receive data width comes from the 2-bit receive length code: 00 selects 5 bits, 01 selects 7, 10 selects 6 and 11 selects 8.
- R3: The transmit data width uses the same mapping as R2 for codes 01, 10 and 11. Code 00 selects a variable width of 5 plus the 2-bit automatic length value (00 gives 5, 11 gives 8). The automatic length value has no effect for the other codes.
- R4: The 2-bit multiplier code scales the sum: 00 gives x1, 01 gives x16, 10 gives x32 and 11 gives x64. The largest frame is 1536 units.
- R5: While a timer is armed, every change of its bit-clock input, rising or falling, removes one unit. The transition that removes the last unit is seen at a `clk` edge, and the done output is high for exactly the one cycle after that edge.
- R6: A start strobe loads the frame length only when the timer is idle. A start strobe while the timer is armed has no effect on when the current frame completes.
- R7: A cancel strobe returns the timer to idle in the next cycle and takes priority over a simultaneous start. No done pulse follows a cancel until the timer is armed again.
- R8: The frame length is captured at arming. Changing the mode fields mid-frame does not alter the current frame; the next frame uses the new values.
- R9: Bit-clock transitions while a timer is idle produce no done pulse.
- R10: All timers, across channels and directions, run independently of one another.
- R11: During reset every done output is low and every timer is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_parity | input | NUM_CH | Parity-enable flag per channel |
| cfg_stop | input | 2*NUM_CH | Stop-bit code per channel |
| cfg_mult | input | 2*NUM_CH | Clock multiplier code per channel |
| rx_char | input | 2*NUM_CH | Receive data width code per channel |
| tx_char | input | 2*NUM_CH | Transmit data width code per channel |
| tx_auto_len | input | 2*NUM_CH | Variable transmit width (5 plus value) per channel |
| tx_bitclk | input | NUM_CH | Transmit bit clock per channel, both edges counted |
| rx_bitclk | input | NUM_CH | Receive bit clock per channel, both edges counted |
| tx_start | input | NUM_CH | Arm transmit timer |
| rx_start | input | NUM_CH | Arm receive timer |
| tx_cancel | input | NUM_CH | Force transmit timer idle |
| rx_cancel | input | NUM_CH | Force receive timer idle |
| tx_done | output | NUM_CH | Transmit frame complete pulse |
| rx_done | output | NUM_CH | Receive frame complete pulse |

## Verification
The bench builds the block with its default of two channels, which gives four timers and lets independence be checked across both channel and direction. Frame lengths are tiny in x1 mode, so every combination of parity, stop code and width code, together with every variable transmit width, is swept at x1 and x16. Each sweep point is checked for a done pulse at exactly the expected transition. The x32 and x64 multipliers are run at selected widths, including the 1536-unit maximum, which exercises the full counter width.

// File: rtl/cft_pkg.sv
package cft_pkg;

  localparam int unsigned UNIT_MAX = 24;
  localparam int unsigned MULT_MAX = 64;
  localparam int unsigned CNT_W    = $clog2(UNIT_MAX * MULT_MAX + 1);
  localparam int unsigned BASE_W   = $clog2(UNIT_MAX + 1);

  typedef logic [CNT_W-1:0]  cnt_t;
  typedef logic [BASE_W-1:0] base_t;

  typedef enum logic [1:0] {
    STOP_SYNC     = 2'b00,
    STOP_ONE      = 2'b01,
    STOP_ONE_HALF = 2'b10,
    STOP_TWO      = 2'b11
  } stop_e;

  typedef enum logic [1:0] {
    MULT_X1  = 2'b00,
    MULT_X16 = 2'b01,
    MULT_X32 = 2'b10,
    MULT_X64 = 2'b11
  } mult_e;

  typedef struct packed {
    logic       parity;
    stop_e      stop;
    mult_e      mult;
    logic [1:0] char_code;
    logic [1:0] auto_len;
  } frame_cfg_t;

  // width code to data bits, shared by both directions
  function automatic logic [3:0] fixed_char_bits(input logic [1:0] code);
    logic [3:0] bits;
    case (code)
      2'b00:   bits = 4'd5;
      2'b01:   bits = 4'd7;
      2'b10:   bits = 4'd6;
      default: bits = 4'd8;
    endcase
    return bits;
  endfunction

  function automatic logic [3:0] tx_char_bits(input logic [1:0] code,
                                              input logic [1:0] auto_len);
    logic [3:0] bits;
    if (code == 2'b00) bits = 4'd5 + {2'b00, auto_len};
    else               bits = fixed_char_bits(code);
    return bits;
  endfunction

endpackage

// File: rtl/cft_rst_sync.sv
module cft_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/cft_len_calc.sv
module cft_len_calc
  import cft_pkg::*;
#(
  parameter bit IS_TX = 1'b0
) (
  input  frame_cfg_t cfg,
  output cnt_t       frame_len
);

  logic [3:0] data_bits;
  base_t      stop_units;
  base_t      base_units;

  generate
    if (IS_TX) begin : g_tx_width
      always_comb data_bits = tx_char_bits(cfg.char_code, cfg.auto_len);
    end else begin : g_rx_width
      logic unused_auto;
      assign unused_auto = ^cfg.auto_len;
      always_comb data_bits = fixed_char_bits(cfg.char_code);
    end
  endgenerate

  always_comb begin
    case (cfg.stop)
      STOP_SYNC:     stop_units = base_t'(0);
      STOP_ONE:      stop_units = base_t'(4);
      STOP_ONE_HALF: stop_units = base_t'(5);
      default:       stop_units = base_t'(6);
    endcase
    base_units = base_t'({cfg.parity, 1'b0}) + base_t'({data_bits, 1'b0}) + stop_units;
  end

  always_comb begin
    case (cfg.mult)
      MULT_X1:  frame_len = cnt_t'(base_units);
      MULT_X16: frame_len = cnt_t'(base_units) << 4;
      MULT_X32: frame_len = cnt_t'(base_units) << 5;
      default:  frame_len = cnt_t'(base_units) << 6;
    endcase
  end

endmodule

// File: rtl/cft_down_counter.sv
module cft_down_counter
  import cft_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic cancel,
  input  logic step,
  input  cnt_t load_val,
  output logic done,
  output logic idle
);

  cnt_t remain_q, remain_d;
  logic done_q, done_d;
  logic remain_en;

  assign idle = (remain_q == '0);

  always_comb begin
    remain_d  = remain_q;
    done_d    = 1'b0;
    remain_en = 1'b0;
    if (cancel) begin
      remain_d  = '0;
      remain_en = 1'b1;
    end else if (idle) begin
      if (start) begin
        remain_d  = load_val;
        remain_en = 1'b1;
      end
    end else if (step) begin
      remain_d  = remain_q - cnt_t'(1);
      remain_en = 1'b1;
      done_d    = (remain_q == cnt_t'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain_q <= '0;
    end else if (remain_en) begin
      remain_q <= remain_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= done_d;
  end

  assign done = done_q;

endmodule

// File: rtl/cft_dir_timer.sv
module cft_dir_timer
  import cft_pkg::*;
#(
  parameter bit IS_TX = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  frame_cfg_t cfg,
  input  logic       bitclk,
  input  logic       start,
  input  logic       cancel,
  output logic       done,
  output logic       idle
);

  cnt_t frame_len;
  logic bitclk_q;
  logic toggle;

  cft_len_calc #(.IS_TX(IS_TX)) u_len (
    .cfg       (cfg),
    .frame_len (frame_len)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bitclk_q <= 1'b0;
    else        bitclk_q <= bitclk;
  end

  assign toggle = bitclk ^ bitclk_q;

  cft_down_counter u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .cancel   (cancel),
    .step     (toggle),
    .load_val (frame_len),
    .done     (done),
    .idle     (idle)
  );

endmodule

// File: rtl/char_frame_timer.sv
module char_frame_timer
  import cft_pkg::*;
#(
  parameter int unsigned NUM_CH = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_CH-1:0]     cfg_parity,
  input  logic [2*NUM_CH-1:0]   cfg_stop,
  input  logic [2*NUM_CH-1:0]   cfg_mult,
  input  logic [2*NUM_CH-1:0]   rx_char,
  input  logic [2*NUM_CH-1:0]   tx_char,
  input  logic [2*NUM_CH-1:0]   tx_auto_len,
  input  logic [NUM_CH-1:0]     tx_bitclk,
  input  logic [NUM_CH-1:0]     rx_bitclk,
  input  logic [NUM_CH-1:0]     tx_start,
  input  logic [NUM_CH-1:0]     rx_start,
  input  logic [NUM_CH-1:0]     tx_cancel,
  input  logic [NUM_CH-1:0]     rx_cancel,
  output logic [NUM_CH-1:0]     tx_done,
  output logic [NUM_CH-1:0]     rx_done
);

  logic              rst_n_int;
  logic [NUM_CH-1:0] tx_idle;
  logic [NUM_CH-1:0] rx_idle;

  cft_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    frame_cfg_t tx_cfg, rx_cfg;

    always_comb begin
      tx_cfg.parity    = cfg_parity[c];
      tx_cfg.stop      = stop_e'(cfg_stop[2*c +: 2]);
      tx_cfg.mult      = mult_e'(cfg_mult[2*c +: 2]);
      tx_cfg.char_code = tx_char[2*c +: 2];
      tx_cfg.auto_len  = tx_auto_len[2*c +: 2];
      rx_cfg           = tx_cfg;
      rx_cfg.char_code = rx_char[2*c +: 2];
      rx_cfg.auto_len  = 2'b00;
    end

    cft_dir_timer #(.IS_TX(1'b1)) u_tx (
      .clk    (clk),
      .rst_n  (rst_n_int),
      .cfg    (tx_cfg),
      .bitclk (tx_bitclk[c]),
      .start  (tx_start[c]),
      .cancel (tx_cancel[c]),
      .done   (tx_done[c]),
      .idle   (tx_idle[c])
    );

    cft_dir_timer #(.IS_TX(1'b0)) u_rx (
      .clk    (clk),
      .rst_n  (rst_n_int),
      .cfg    (rx_cfg),
      .bitclk (rx_bitclk[c]),
      .start  (rx_start[c]),
      .cancel (rx_cancel[c]),
      .done   (rx_done[c]),
      .idle   (rx_idle[c])
    );
  end

endmodule

// File: rtl/cft_checker.sv
module cft_checker #(
  parameter int unsigned NUM_CH = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] tx_bitclk,
  input logic [NUM_CH-1:0] rx_bitclk,
  input logic [NUM_CH-1:0] tx_start,
  input logic [NUM_CH-1:0] rx_start,
  input logic [NUM_CH-1:0] tx_cancel,
  input logic [NUM_CH-1:0] rx_cancel,
  input logic [NUM_CH-1:0] tx_done,
  input logic [NUM_CH-1:0] rx_done,
  input logic [NUM_CH-1:0] tx_idle,
  input logic [NUM_CH-1:0] rx_idle
);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    // R5: completion is a single-cycle pulse
    assert_tx_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      tx_done[c] |=> !tx_done[c]);
    assert_rx_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rx_done[c] |=> !rx_done[c]);

    // R5, R9: a pulse always follows a sampled bit-clock transition
    assert_tx_after_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
      tx_done[c] |-> ($past(tx_bitclk[c], 1) != $past(tx_bitclk[c], 2)));
    assert_rx_after_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rx_done[c] |-> ($past(rx_bitclk[c], 1) != $past(rx_bitclk[c], 2)));

    // R7: cancel silences completion and idles the timer
    assert_tx_cancel_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      tx_cancel[c] |=> (!tx_done[c] && tx_idle[c]));
    assert_rx_cancel_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rx_cancel[c] |=> (!rx_done[c] && rx_idle[c]));

    // R6: arming an idle timer leaves it busy
    assert_tx_arm_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_idle[c] && tx_start[c] && !tx_cancel[c]) |=> !tx_idle[c]);
    assert_rx_arm_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_idle[c] && rx_start[c] && !rx_cancel[c]) |=> !rx_idle[c]);
  end

endmodule

bind char_frame_timer cft_checker #(.NUM_CH(NUM_CH)) u_cft_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .tx_bitclk (tx_bitclk),
  .rx_bitclk (rx_bitclk),
  .tx_start  (tx_start),
  .rx_start  (rx_start),
  .tx_cancel (tx_cancel),
  .rx_cancel (rx_cancel),
  .tx_done   (tx_done),
  .rx_done   (rx_done),
  .tx_idle   (tx_idle),
  .rx_idle   (rx_idle)
);

// File: tb/sim_char_frame_timer.sv
module sim_char_frame_timer;

  localparam int NCH = 2;

  logic           clk;
  logic           rst_n;
  logic [NCH-1:0] cfg_parity;
  logic [2*NCH-1:0] cfg_stop, cfg_mult, rx_char, tx_char, tx_auto_len;
  logic [NCH-1:0] tx_bitclk, rx_bitclk, tx_start, rx_start, tx_cancel, rx_cancel;
  logic [NCH-1:0] tx_done, rx_done;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit finished = 0;

  char_frame_timer #(.NUM_CH(NCH)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_parity(cfg_parity), .cfg_stop(cfg_stop),
    .cfg_mult(cfg_mult), .rx_char(rx_char), .tx_char(tx_char),
    .tx_auto_len(tx_auto_len), .tx_bitclk(tx_bitclk), .rx_bitclk(rx_bitclk),
    .tx_start(tx_start), .rx_start(rx_start), .tx_cancel(tx_cancel),
    .rx_cancel(rx_cancel), .tx_done(tx_done), .rx_done(rx_done)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual cycles=%0d expected <150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int exp_len(input bit is_tx, input int par, input int stp,
                                 input int mul, input int cc, input int al);
    int bits, su, m;
    case (cc)
      0:       bits = is_tx ? 5 + al : 5;
      1:       bits = 7;
      2:       bits = 6;
      default: bits = 8;
    endcase
    case (stp)
      0: su = 0; 1: su = 4; 2: su = 5; default: su = 6;
    endcase
    case (mul)
      0: m = 1; 1: m = 16; 2: m = 32; default: m = 64;
    endcase
    return (2 * par + 2 * bits + su) * m;
  endfunction

  task automatic set_cfg(input int ch, input int par, input int stp, input int mul,
                         input int cc, input int al);
    cfg_parity[ch]        = par[0];
    cfg_stop[2*ch +: 2]   = stp[1:0];
    cfg_mult[2*ch +: 2]   = mul[1:0];
    rx_char[2*ch +: 2]    = cc[1:0];
    tx_char[2*ch +: 2]    = cc[1:0];
    tx_auto_len[2*ch +: 2] = al[1:0];
  endtask

  task automatic toggle(input bit is_tx, input int ch);
    if (is_tx) tx_bitclk[ch] = ~tx_bitclk[ch];
    else       rx_bitclk[ch] = ~rx_bitclk[ch];
  endtask

  function automatic bit done_of(input bit is_tx, input int ch);
    return is_tx ? tx_done[ch] : rx_done[ch];
  endfunction

  task automatic arm(input bit is_tx, input int ch);
    if (is_tx) tx_start[ch] = 1'b1; else rx_start[ch] = 1'b1;
    cyc();
    if (is_tx) tx_start[ch] = 1'b0; else rx_start[ch] = 1'b0;
  endtask

  // counts toggles; returns toggle index of first done (0 if none) and done count
  task automatic run_toggles(input bit is_tx, input int ch, input int n,
                             output int first, output int hits);
    first = 0; hits = 0;
    for (int k = 1; k <= n; k++) begin
      toggle(is_tx, ch);
      cyc();
      if (done_of(is_tx, ch)) begin
        hits++;
        if (first == 0) first = k;
      end
    end
  endtask

  task automatic run_frame(input bit is_tx, input int ch, input int len, input string req);
    int first, hits;
    arm(is_tx, ch);
    run_toggles(is_tx, ch, len, first, hits);
    check(first == len && hits == 1, req, first, len);
    cyc();
    check(!done_of(is_tx, ch), "R5 pulse width", int'(done_of(is_tx, ch)), 0);
  endtask

  initial begin
    int first, hits, other;
    rst_n = 1'b0;
    cfg_parity = '0; cfg_stop = '0; cfg_mult = '0; rx_char = '0; tx_char = '0;
    tx_auto_len = '0; tx_bitclk = '0; rx_bitclk = '0; tx_start = '0; rx_start = '0;
    tx_cancel = '0; rx_cancel = '0;
    repeat (3) @(negedge clk);
    // R11: outputs quiet during reset
    check(tx_done == '0 && rx_done == '0, "R11 reset done", int'({tx_done, rx_done}), 0);
    rst_n = 1'b1;
    repeat (5) cyc();
    check(tx_done == '0 && rx_done == '0, "R11 after reset", int'({tx_done, rx_done}), 0);

    // R1 R2 R4: receive sweep at x1 and x16
    for (int mul = 0; mul < 2; mul++)
      for (int par = 0; par < 2; par++)
        for (int stp = 0; stp < 4; stp++)
          for (int cc = 0; cc < 4; cc++) begin
            set_cfg(0, par, stp, mul, cc, 0);
            run_frame(1'b0, 0, exp_len(1'b0, par, stp, mul, cc, 0), "R1 R2 R4 rx sweep");
          end

    // R1 R3 R4: transmit sweep including variable width; auto value ignored for fixed codes
    for (int mul = 0; mul < 2; mul++)
      for (int par = 0; par < 2; par++)
        for (int stp = 0; stp < 4; stp++)
          for (int cc = 0; cc < 4; cc++)
            for (int al = 0; al < 4; al++) begin
              if (cc != 0 && al != 3) continue;
              set_cfg(1, par, stp, mul, cc, al);
              run_frame(1'b1, 1, exp_len(1'b1, par, stp, mul, cc, al), "R3 tx sweep");
            end

    // R4: large multipliers, including the maximum frame
    set_cfg(1, 1, 3, 3, 3, 0);
    run_frame(1'b0, 1, 1536, "R4 x64 max");
    set_cfg(0, 0, 2, 2, 0, 0);
    run_frame(1'b1, 0, 480, "R4 x32");

    // R6: start while busy does not restart the frame
    set_cfg(0, 0, 0, 0, 0, 0);
    arm(1'b0, 0);
    run_toggles(1'b0, 0, 4, first, hits);
    arm(1'b0, 0);
    run_toggles(1'b0, 0, 6, first, hits);
    check(first == 6 && hits == 1, "R6 busy start ignored", first, 6);
    cyc();

    // R7: cancel with simultaneous start, then silence
    set_cfg(0, 0, 1, 0, 3, 0);
    arm(1'b1, 0);
    run_toggles(1'b1, 0, 3, first, hits);
    tx_cancel[0] = 1'b1; tx_start[0] = 1'b1;
    cyc();
    tx_cancel[0] = 1'b0; tx_start[0] = 1'b0;
    run_toggles(1'b1, 0, 30, first, hits);
    check(hits == 0, "R7 cancel silences", hits, 0);
    run_frame(1'b1, 0, 20, "R7 rearm after cancel");

    // R8: mode change mid-frame affects only the next frame
    set_cfg(0, 0, 0, 0, 0, 0);
    arm(1'b0, 0);
    run_toggles(1'b0, 0, 3, first, hits);
    set_cfg(0, 0, 0, 0, 3, 0);
    run_toggles(1'b0, 0, 7, first, hits);
    check(first == 7 && hits == 1, "R8 latched length", first, 7);
    cyc();
    run_frame(1'b0, 0, 16, "R8 next frame new length");

    // R9: idle toggling
    run_toggles(1'b0, 1, 40, first, hits);
    check(hits == 0, "R9 idle rx toggles", hits, 0);
    run_toggles(1'b1, 1, 40, first, hits);
    check(hits == 0, "R9 idle tx toggles", hits, 0);

    // R10: neighbours toggle while rx ch0 runs a 10-unit frame
    set_cfg(0, 0, 0, 0, 0, 0);
    arm(1'b0, 0);
    first = 0; hits = 0; other = 0;
    for (int k = 1; k <= 10; k++) begin
      toggle(1'b0, 0); toggle(1'b0, 1); toggle(1'b1, 0); toggle(1'b1, 1);
      cyc();
      if (rx_done[0]) begin hits++; if (first == 0) first = k; end
      if (rx_done[1] || tx_done != '0) other++;
    end
    check(first == 10 && hits == 1, "R10 own frame exact", first, 10);
    check(other == 0, "R10 neighbours quiet", other, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule